// File: doc/BRIEF.md
# Key-Guarded Configuration Write Lock

This block sits on the write path between a simple register port and a bank of configuration registers. When the lock is engaged, writes aimed at a fixed set of guarded offsets are held back, so the bank never sees its write enable for them. Writes to every other offset go through unchanged.

The lock is engaged and released through a lock-control register. A write there takes effect only when the upper 24 bits of the write data carry the fixed unlock code. Every held-back write is logged in a status register. The log keeps a sticky flag and the offset of the most recent offending write. Reading the status register returns the log and empties it. The flag is also driven on a dedicated output so that it can feed an interrupt.

Top module: `cfg_write_guard`

## Requirements
- R1: After synchronous reset the lock is off, the status flag and recorded offset are zero, and `viol` is low.
- R2: A write to offset 0xE4 whose data bits 31:8 equal 0x414443 loads data bit 0 into the lock. A read of 0xE4 returns the lock in bit 0 and zero in all other bits.
- R3: A write to offset 0xE4 with any other value in bits 31:8 leaves the lock unchanged.
- R4: While the lock is on, a write to any guarded offset (0x04, 0x08, 0x0C, 0x40, 0x44, 0x48, 0x4C, 0x94, 0xB0, 0xC0) keeps `wr_pass` low in that cycle.
- R5: A write to a non-guarded offset drives `wr_pass` high in the same cycle whatever the lock state. While the lock is off, writes to guarded offsets also pass and are not logged.
- R6: A held-back write sets the status flag. The flag appears in bit 0 of a read at 0xE8 and on `viol` from the next cycle. The write's offset is recorded zero-extended in status bits 23:8.
- R7: When several writes are held back before a status read, the recorded offset is that of the latest one.
- R8: A read of 0xE8 returns the current status in the same cycle and clears both the flag and the offset at the following clock edge.
- R9: `rdata` is zero when `rd_en` is low or when the read offset is neither 0xE4 nor 0xE8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the register port |
| rd_en | input | 1 | Read strobe from the register port |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| wr_pass | output | 1 | Write enable forwarded to the configuration bank |
| rdata | output | 32 | Read data for the lock-control and status registers |
| viol | output | 1 | Sticky violation flag |

## Verification
The hardest case to reach is a status log that holds several violations, where only the last offset may remain. The stimulus first turns the lock on with the correct code. It then issues a wrong-code write, which must not undo the lock. After that it fires a run of writes at different guarded offsets with no read in between. The final status read must show only the last offset, and a second read must show an empty log. The bench also walks through every guarded offset while the lock is on. It repeats the walk after releasing the lock, to check that the list cuts both ways.

// File: rtl/wg_pkg.sv
package wg_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 24;
    localparam int CODE_LSB = DATA_W - CODE_W;
    localparam int SRC_W    = 16;
    localparam int SRC_LSB  = 8;

    localparam logic [ADDR_W-1:0] LOCK_OFS = 8'hE4;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'hE8;
    localparam logic [CODE_W-1:0] UNLOCK_CODE = 24'h414443;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             flag;
    } wg_status_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOCK = 2'd1,
        SEL_STAT = 2'd2
    } wg_rsel_e;

    function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
        case (a)
            8'h04, 8'h08, 8'h0C,
            8'h40, 8'h44, 8'h48, 8'h4C,
            8'h94, 8'hB0, 8'hC0: return 1'b1;
            default:             return 1'b0;
        endcase
    endfunction

    function automatic wg_rsel_e decode_read(input logic [ADDR_W-1:0] a);
        if (a == LOCK_OFS)      return SEL_LOCK;
        else if (a == STAT_OFS) return SEL_STAT;
        else                    return SEL_NONE;
    endfunction
endpackage

// File: rtl/wg_lock.sv
module wg_lock
    import wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              lock_on
);
    logic code_ok;
    assign code_ok = (wdata[DATA_W-1:CODE_LSB] == UNLOCK_CODE);

    always_ff @(posedge clk) begin
        if (rst)                     lock_on <= 1'b0;
        else if (lock_wr && code_ok) lock_on <= wdata[0];
    end
endmodule

// File: rtl/wg_log.sv
module wg_log
    import wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [ADDR_W-1:0] hold_addr,
    input  logic              rd_clear,
    output wg_status_t        status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (hold) begin
            status.flag <= 1'b1;
            status.src  <= SRC_W'(hold_addr);
        end else if (rd_clear) begin
            status <= '0;
        end
    end
endmodule

// File: rtl/wg_rdmux.sv
module wg_rdmux
    import wg_pkg::*;
(
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_on,
    input  wg_status_t        status,
    output logic [DATA_W-1:0] rdata
);
    wg_rsel_e sel;
    assign sel = rd_en ? decode_read(addr) : SEL_NONE;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_LOCK: rdata[0] = lock_on;
            SEL_STAT: begin
                rdata[0]                      = status.flag;
                rdata[SRC_LSB +: SRC_W]       = status.src;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
    import wg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_pass,
    output logic [DATA_W-1:0] rdata,
    output logic              viol
);
    logic       lock_on;
    logic       hold;
    wg_status_t status;

    assign hold    = wr_en && lock_on && is_guarded(addr);
    assign wr_pass = wr_en && !hold;
    assign viol    = status.flag;

    wg_lock u_lock (
        .clk     (clk),
        .rst     (rst),
        .lock_wr (wr_en && (addr == LOCK_OFS)),
        .wdata   (wdata),
        .lock_on (lock_on)
    );

    wg_log u_log (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .hold_addr (addr),
        .rd_clear  (rd_en && (addr == STAT_OFS)),
        .status    (status)
    );

    wg_rdmux u_rdmux (
        .rd_en   (rd_en),
        .addr    (addr),
        .lock_on (lock_on),
        .status  (status),
        .rdata   (rdata)
    );
endmodule

// File: rtl/wg_checker.sv
module wg_checker
    import wg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wr_pass,
    input logic [DATA_W-1:0] rdata,
    input logic              viol,
    input logic              lock_on
);
    AST_BAD_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == LOCK_OFS && wdata[DATA_W-1:CODE_LSB] != UNLOCK_CODE |=> $stable(lock_on)); // R3
    AST_GOOD_CODE_LOADS: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == LOCK_OFS && wdata[DATA_W-1:CODE_LSB] == UNLOCK_CODE |=> lock_on == $past(wdata[0])); // R2
    AST_GUARDED_HELD: assert property (@(posedge clk) disable iff (rst)
        lock_on && wr_en && is_guarded(addr) |-> !wr_pass); // R4
    AST_FREE_PASS: assert property (@(posedge clk) disable iff (rst)
        wr_en && !is_guarded(addr) |-> wr_pass); // R5
    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_pass |=> viol); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == STAT_OFS && !wr_en |=> !viol); // R8
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rdata == '0); // R9
endmodule

bind cfg_write_guard wg_checker u_wg_checker (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .wr_pass (wr_pass),
    .rdata   (rdata),
    .viol    (viol),
    .lock_on (lock_on)
);

// File: tb/tb_cfg_write_guard.sv
`timescale 1ns/100ps
module tb_cfg_write_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_pass;
    logic [31:0] rdata;
    logic        viol;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [33:0] exp_q[$];
    string       tag_q[$];
    event        sample_ev;

    logic        m_on   = 1'b0;
    logic        m_flag = 1'b0;
    logic [15:0] m_src  = '0;

    localparam logic [7:0] GUARDED [10] = '{8'h04, 8'h08, 8'h0C, 8'h40, 8'h44,
                                            8'h48, 8'h4C, 8'h94, 8'hB0, 8'hC0};

    always #2.5 clk = ~clk;

    cfg_write_guard dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .wr_pass(wr_pass), .rdata(rdata), .viol(viol)
    );

    function automatic logic guarded(input logic [7:0] a);
        foreach (GUARDED[i]) if (GUARDED[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    // driver: apply one access, push expected outputs, advance the model
    task automatic op(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
        logic        blk;
        logic [31:0] er;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        blk = w && m_on && guarded(a);
        er  = '0;
        if (r && a == 8'hE4) er = {31'b0, m_on};
        if (r && a == 8'hE8) er = {8'b0, m_src, 7'b0, m_flag};
        exp_q.push_back({!blk && w, m_flag, er});
        tag_q.push_back(tag);
        #1 -> sample_ev;
        if (w && a == 8'hE4 && d[31:8] == 24'h414443) m_on = d[0];
        if (r && a == 8'hE8) begin m_flag = 1'b0; m_src = '0; end
        if (blk) begin m_flag = 1'b1; m_src = {8'b0, a}; end
    endtask

    // monitor: compare observed outputs against the queue
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                logic [33:0] e;
                logic [33:0] got;
                string       t;
                e   = exp_q.pop_front();
                t   = tag_q.pop_front();
                got = {wr_pass, viol, rdata};
                n_checks++;
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s: got pass=%b viol=%b rdata=%h, expected pass=%b viol=%b rdata=%h",
                             t, got[33], got[32], got[31:0], e[33], e[32], e[31:0]);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        op(0, 1, 8'hE8, 0, "R1 status after reset");
        op(0, 1, 8'hE4, 0, "R1 lock after reset");
        op(1, 0, 8'hE4, 32'h41444201, "R3 wrong code write");
        op(0, 1, 8'hE4, 0, "R3 lock still off");
        op(1, 0, 8'hE4, 32'h41444301, "R2 correct code engages");
        op(0, 1, 8'hE4, 0, "R2 lock reads one");
        op(1, 0, 8'h04, 32'hDEAD, "R4 guarded write held");
        op(0, 1, 8'hE8, 0, "R6 status logs offset");
        op(0, 1, 8'hE8, 0, "R8 status cleared by read");
        op(1, 0, 8'h10, 32'h1, "R5 free offset passes while locked");
        op(1, 0, 8'hE4, 32'h00000000, "R3 wrong code while locked");
        op(0, 1, 8'hE4, 0, "R3 lock still on");
        op(1, 0, 8'h40, 0, "R7 first held write");
        op(0, 0, 8'h00, 0, "R6 viol raised");
        op(1, 0, 8'hC0, 0, "R7 second held write");
        op(0, 1, 8'hE8, 0, "R7 latest offset kept");
        op(0, 1, 8'hE8, 0, "R8 empty after read");
        foreach (GUARDED[i]) op(1, 0, GUARDED[i], 32'h5A, "R4 sweep locked");
        op(0, 1, 8'hE8, 0, "R7 sweep last offset");
        op(1, 0, 8'hE4, 32'h41444300, "R2 correct code releases");
        foreach (GUARDED[i]) op(1, 0, GUARDED[i], 32'hA5, "R5 sweep unlocked");
        op(0, 1, 8'hE8, 0, "R5 nothing logged when unlocked");
        op(0, 1, 8'h20, 0, "R9 unmapped read zero");
        op(0, 0, 8'hE4, 0, "R9 no read strobe zero");
        op(0, 0, 8'h00, 0, "R9 idle");
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule